// File: doc/BRIEF.md
# Two-Stage Multicast Arbitration Controller

This block schedules head-of-queue packets for every input port of one switch slice. It sits between the input queues and the per-output arbiters. A unicast head sends its one destination request straight to the output arbiters. A multicast head first has to win a single token, which one round-robin arbiter shares across all ports. Only the port that holds the token may raise requests to several outputs in the same cycle. Because of this, two multicast ports can never each win part of their outputs and then wait on each other forever.

While a port holds the token, a per-packet timer counts its cycles. When the timer passes the packet's limit, the outputs granted so far are served and the token is given up. The outputs not yet served stay in a residual mask and are requested again in a later round. A limit of all ones never expires, so the packet waits until every destination grants in the same cycle. A port that loses the token waits a fixed gap before it asks again.

Top module: `mcast_sched`

## Requirements
- R1: After reset, all request, fire, fire-mask and done outputs are 0 and no port holds the multicast token.
- R2: A valid unicast head (`head_mc_i`=0) drives its one-hot destination mask onto its `req_o` slice in the same cycle. In a cycle where that destination's grant bit is 1, `fire_o`, `done_o` and a fire mask equal to the destination all assert combinationally.
- R3: A multicast head (`head_mc_i`=1) drives no request in the cycle it is first seen valid or in its token-request cycle. Its full destination mask appears on `req_o` from the cycle after it wins the token.
- R4: At most one port holds the token at a time. Only the holder drives a multi-destination request. Among ports requesting the token in the same cycle, the first one found searching upward from the pointer (with wrap-around) wins. The pointer then moves to one past the winner.
- R5: A port that loses the token waits RETRY_GAP cycles before it requests again. Once the token is freed, a waiting port is driving its request within RETRY_GAP+1 cycles.
- R6: With limit all ones, a multicast packet fires only in a cycle where every residual destination is granted. It then fires with the whole residual mask and asserts done.
- R7: With a finite limit L, the timer reads 0 in the first cycle with the token and counts up by one each cycle. Once it reaches L, any granted subset of the residual fires without done. The token is then given up, the port asks for the token again, and it requests only the remaining outputs.
- R8: Limit 0 allows a partial fire in the first cycle the token is held.
- R9: A fire with done returns the port to idle and frees the token, so another port can win it on its next request.
- R10: Grant bits for outputs the port is not requesting have no effect. They neither cause a fire nor appear in the fire mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| head_vld_i | input | NUM_PORTS | Head packet present, per port |
| head_mc_i | input | NUM_PORTS | 1 = multicast head, 0 = unicast head |
| head_dst_i | input | NUM_PORTS*NUM_OUTS | Destination mask; port p uses bits [p*NUM_OUTS +: NUM_OUTS], bit o = output o |
| head_tmo_i | input | NUM_PORTS*TMR_W | Per-packet timeout limit; all ones = infinite |
| gnt_i | input | NUM_PORTS*NUM_OUTS | Grants from the output arbiters, same layout as head_dst_i |
| req_o | output | NUM_PORTS*NUM_OUTS | Requests to the output arbiters, same layout as head_dst_i |
| fire_o | output | NUM_PORTS | Port transfers to the outputs in fire_mask_o this cycle |
| fire_mask_o | output | NUM_PORTS*NUM_OUTS | Outputs served by this transfer |
| done_o | output | NUM_PORTS | Head fully delivered; dequeue it |

## Verification
Single unicast heads are driven with grants on both matching and non-matching outputs. This separates a real transfer from grants that must be ignored. Multicast heads are run with an infinite limit, a limit of two and a limit of zero, each with grants that cover only part of the destinations. This shows whether the timer decides between holding, partial delivery and re-arbitration for the rest. Two overlapping multicast heads are then started in the same cycle, once with the pointer below both and once with it between them. These runs show that only one port is requesting, that the round-robin order holds, and that the losing port comes back within the retry gap.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_TOKREQ = 2'd1,
    ST_WAIT   = 2'd2,
    ST_ACTIVE = 2'd3
  } pst_e;
endpackage

// File: rtl/mcs_rr_arb.sv
module mcs_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         release_i,
  output logic [N-1:0] gnt_o
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic             busy_q;
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] win;
  logic [IDX_W-1:0] idx;
  logic             found;

  // search upward from ptr_q, wrap around; only while token is free
  always_comb begin
    gnt_o = '0;
    win   = ptr_q;
    idx   = '0;
    found = 1'b0;
    if (!busy_q) begin
      for (int k = 0; k < N; k++) begin
        idx = IDX_W'((int'(ptr_q) + k) % N);
        if (!found && req_i[idx]) begin
          found = 1'b1;
          win   = idx;
        end
      end
    end
    if (found) gnt_o[win] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
    end else if (release_i) begin
      busy_q <= 1'b0;
    end else if (found) begin
      busy_q <= 1'b1;
      ptr_q  <= (win == IDX_W'(N - 1)) ? '0 : win + 1'b1;
    end
  end

  // R9
  release_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |-> busy_q);

  // R4
  grant_locks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o) |=> (busy_q && gnt_o == '0));
endmodule

// File: rtl/mcs_tmo_timer.sv
module mcs_tmo_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [TMR_W-1:0] limit_i,
  output logic             expired_o
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!run_i)     cnt_q <= '0;
    else if (~&cnt_q)    cnt_q <= cnt_q + 1'b1;
  end

  // all-ones limit never expires
  assign expired_o = run_i && !(&limit_i) && (cnt_q >= limit_i);
endmodule

// File: rtl/mcs_port_ctl.sv
module mcs_port_ctl
  import mcs_pkg::*;
#(
  parameter int M     = 4,
  parameter int TMR_W = 8,
  parameter int GAP   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             mc_i,
  input  logic [M-1:0]     dst_i,
  input  logic [TMR_W-1:0] tmo_i,
  input  logic [M-1:0]     gnt_i,
  input  logic             tok_gnt_i,
  output logic             tok_req_o,
  output logic [M-1:0]     req_o,
  output logic             fire_o,
  output logic [M-1:0]     fire_mask_o,
  output logic             done_o,
  output logic             release_o,
  output logic             active_o
);
  localparam int GAP_W = (GAP > 1) ? $clog2(GAP) : 1;

  pst_e             st_q, st_d;
  logic [M-1:0]     resid_q, resid_d;
  logic [TMR_W-1:0] lim_q;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic [M-1:0]     hit;
  logic             all_hit;
  logic             expired;

  mcs_tmo_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (active_o),
    .limit_i   (lim_q),
    .expired_o (expired)
  );

  assign active_o = (st_q == ST_ACTIVE);

  always_comb begin
    st_d        = st_q;
    resid_d     = resid_q;
    gap_d       = gap_q;
    req_o       = '0;
    tok_req_o   = 1'b0;
    fire_o      = 1'b0;
    fire_mask_o = '0;
    done_o      = 1'b0;
    hit         = '0;
    all_hit     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (vld_i && !mc_i) begin
          // unicast: no first stage
          req_o       = dst_i;
          hit         = dst_i & gnt_i;
          fire_o      = |hit;
          fire_mask_o = hit;
          done_o      = |hit;
        end else if (vld_i && mc_i && (|dst_i)) begin
          st_d    = ST_TOKREQ;
          resid_d = dst_i;
        end
      end
      ST_TOKREQ: begin
        tok_req_o = 1'b1;
        if (tok_gnt_i) begin
          st_d = ST_ACTIVE;
        end else begin
          st_d  = ST_WAIT;
          gap_d = GAP_W'(GAP - 1);
        end
      end
      ST_WAIT: begin
        if (gap_q == '0) st_d = ST_TOKREQ;
        else             gap_d = gap_q - 1'b1;
      end
      ST_ACTIVE: begin
        req_o   = resid_q;
        hit     = resid_q & gnt_i;
        all_hit = (hit == resid_q);
        if (all_hit || (expired && (|hit))) begin
          fire_o      = 1'b1;
          fire_mask_o = hit;
          done_o      = all_hit;
          resid_d     = resid_q & ~hit;
          st_d        = all_hit ? ST_IDLE : ST_TOKREQ;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign release_o = active_o && fire_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      resid_q <= '0;
      lim_q   <= '0;
      gap_q   <= '0;
    end else begin
      st_q    <= st_d;
      resid_q <= resid_d;
      gap_q   <= gap_d;
      if (st_q == ST_IDLE) lim_q <= tmo_i;
    end
  end

  // R3
  token_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(tok_gnt_i));

  // R6
  inf_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && fire_o && (&lim_q)) |-> done_o);

  // R7
  partial_rearb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && fire_o && !done_o) |=> tok_req_o);
endmodule

// File: rtl/mcast_sched.sv
module mcast_sched #(
  parameter int NUM_PORTS = 4,
  parameter int NUM_OUTS  = 4,
  parameter int TMR_W     = 8,
  parameter int RETRY_GAP = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_PORTS-1:0]          head_vld_i,
  input  logic [NUM_PORTS-1:0]          head_mc_i,
  input  logic [NUM_PORTS*NUM_OUTS-1:0] head_dst_i,
  input  logic [NUM_PORTS*TMR_W-1:0]    head_tmo_i,
  input  logic [NUM_PORTS*NUM_OUTS-1:0] gnt_i,
  output logic [NUM_PORTS*NUM_OUTS-1:0] req_o,
  output logic [NUM_PORTS-1:0]          fire_o,
  output logic [NUM_PORTS*NUM_OUTS-1:0] fire_mask_o,
  output logic [NUM_PORTS-1:0]          done_o
);
  logic [NUM_PORTS-1:0] tok_req;
  logic [NUM_PORTS-1:0] tok_gnt;
  logic [NUM_PORTS-1:0] rel;
  logic [NUM_PORTS-1:0] act;

  mcs_rr_arb #(.N(NUM_PORTS)) u_tok_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (tok_req),
    .release_i (|rel),
    .gnt_o     (tok_gnt)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    mcs_port_ctl #(
      .M     (NUM_OUTS),
      .TMR_W (TMR_W),
      .GAP   (RETRY_GAP)
    ) u_ctl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .vld_i       (head_vld_i[p]),
      .mc_i        (head_mc_i[p]),
      .dst_i       (head_dst_i[p*NUM_OUTS +: NUM_OUTS]),
      .tmo_i       (head_tmo_i[p*TMR_W +: TMR_W]),
      .gnt_i       (gnt_i[p*NUM_OUTS +: NUM_OUTS]),
      .tok_gnt_i   (tok_gnt[p]),
      .tok_req_o   (tok_req[p]),
      .req_o       (req_o[p*NUM_OUTS +: NUM_OUTS]),
      .fire_o      (fire_o[p]),
      .fire_mask_o (fire_mask_o[p*NUM_OUTS +: NUM_OUTS]),
      .done_o      (done_o[p]),
      .release_o   (rel[p]),
      .active_o    (act[p])
    );
  end

  // R4
  single_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act));
endmodule

// File: tb/mcast_sched_tb.sv
module mcast_sched_tb;
  localparam int N   = 4;
  localparam int M   = 4;
  localparam int TW  = 4;
  localparam int GAP = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n;
  logic [N-1:0]    vld, mc;
  logic [N*M-1:0]  dst, gnt;
  logic [N*TW-1:0] tmo;
  logic [N*M-1:0]  req_o, fire_mask_o;
  logic [N-1:0]    fire_o, done_o;

  mcast_sched #(.NUM_PORTS(N), .NUM_OUTS(M), .TMR_W(TW), .RETRY_GAP(GAP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .head_vld_i(vld), .head_mc_i(mc),
    .head_dst_i(dst), .head_tmo_i(tmo), .gnt_i(gnt), .req_o(req_o),
    .fire_o(fire_o), .fire_mask_o(fire_mask_o), .done_o(done_o)
  );

  int checks = 0;
  int errors = 0;

  typedef struct { int port; logic [M-1:0] mask; logic done; string rq; } exp_t;
  exp_t expq[$];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [M-1:0] rq(input int p);
    return req_o[p*M +: M];
  endfunction

  task automatic push(input int p, input logic [M-1:0] m, input logic d, input string r);
    exp_t e;
    e.port = p; e.mask = m; e.done = d; e.rq = r;
    expq.push_back(e);
  endtask

  task automatic go();
    @(posedge clk); #1;
  endtask

  task automatic setp(input int p, input logic v, input logic c,
                      input logic [M-1:0] d, input logic [TW-1:0] t);
    vld[p] = v; mc[p] = c; dst[p*M +: M] = d; tmo[p*TW +: TW] = t;
  endtask

  task automatic setg(input int p, input logic [M-1:0] g);
    gnt[p*M +: M] = g;
  endtask

  // monitor: every fire is compared with the scoreboard front
  always @(negedge clk) begin
    if (rst_n) begin
      for (int p = 0; p < N; p++) begin
        if (fire_o[p]) begin
          if (expq.size() == 0) begin
            chk(1'b0, "R10", "unexpected fire on port", p, 32'hff);
          end else begin
            exp_t e;
            e = expq.pop_front();
            chk(e.port == p, e.rq, "fire port", p, e.port);
            chk(fire_mask_o[p*M +: M] == e.mask, e.rq, "fire mask",
                fire_mask_o[p*M +: M], e.mask);
            chk(done_o[p] == e.done, e.rq, "done", done_o[p], e.done);
          end
        end
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int wc;
    bit found;
    rst_n = 1'b0; vld = '0; mc = '0; dst = '0; gnt = '0; tmo = '0;
    repeat (3) go();
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_o == '0, "R1", "req after reset", req_o, 0);
    chk(fire_o == '0 && done_o == '0, "R1", "fire/done after reset", {fire_o, done_o}, 0);

    // R2 unicast, R10 unrelated grant
    go(); setp(0, 1, 0, 4'b0010, 0);
    @(negedge clk);
    chk(rq(0) == 4'b0010, "R2", "unicast req", rq(0), 4'b0010);
    chk(fire_o[0] == 1'b0, "R2", "no fire without grant", fire_o[0], 0);
    go(); setg(0, 4'b0001);
    @(negedge clk);
    chk(fire_o[0] == 1'b0, "R10", "foreign grant ignored", fire_o[0], 0);
    go(); setg(0, 4'b0011); push(0, 4'b0010, 1'b1, "R2");
    @(negedge clk);
    chk(done_o[0] == 1'b1, "R2", "unicast done", done_o[0], 1);
    go(); setp(0, 0, 0, 0, 0); setg(0, 0);

    // R3 / R6 multicast, infinite limit
    go(); setp(1, 1, 1, 4'b1011, 4'hf);
    @(negedge clk);
    chk(rq(1) == '0, "R3", "no req when first seen", rq(1), 0);
    go(); @(negedge clk);
    chk(rq(1) == '0, "R3", "no req while asking token", rq(1), 0);
    go(); @(negedge clk);
    chk(rq(1) == 4'b1011, "R3", "full req after token", rq(1), 4'b1011);
    go(); setg(1, 4'b0011);
    @(negedge clk);
    chk(fire_o[1] == 1'b0, "R6", "hold on partial grant", fire_o[1], 0);
    go(); @(negedge clk);
    chk(fire_o[1] == 1'b0, "R6", "still holding", fire_o[1], 0);
    go(); setg(1, 4'b1011); push(1, 4'b1011, 1'b1, "R6");
    @(negedge clk);
    go(); setp(1, 0, 0, 0, 0); setg(1, 0);
    @(negedge clk);
    chk(rq(1) == '0, "R9", "idle after done", rq(1), 0);

    // R7 finite limit 2
    go(); setp(2, 1, 1, 4'b0111, 4'd2); setg(2, 4'b0001);
    go(); go(); @(negedge clk);
    chk(fire_o[2] == 1'b0, "R7", "timer 0 no fire", fire_o[2], 0);
    go(); @(negedge clk);
    chk(fire_o[2] == 1'b0, "R7", "timer 1 no fire", fire_o[2], 0);
    go(); push(2, 4'b0001, 1'b0, "R7");
    @(negedge clk);
    go(); @(negedge clk);
    chk(rq(2) == '0, "R7", "re-asking token", rq(2), 0);
    go(); setg(2, 4'b0110); push(2, 4'b0110, 1'b1, "R7");
    @(negedge clk);
    chk(rq(2) == 4'b0110, "R7", "remaining outputs only", rq(2), 4'b0110);
    go(); setp(2, 0, 0, 0, 0); setg(2, 0);

    // R8 limit 0, R10 stale grant outside residual
    go(); setp(3, 1, 1, 4'b1100, 4'd0); setg(3, 4'b0100);
    go(); go(); push(3, 4'b0100, 1'b0, "R8");
    @(negedge clk);
    go(); setg(3, 4'b1100);
    @(negedge clk);
    chk(rq(3) == '0, "R8", "re-asking after partial", rq(3), 0);
    go(); push(3, 4'b1000, 1'b1, "R10");
    @(negedge clk);
    chk(rq(3) == 4'b1000, "R8", "residual req", rq(3), 4'b1000);
    go(); setp(3, 0, 0, 0, 0); setg(3, 0);

    // R4 / R5 / R9 contention, pointer at 0: port 1 wins
    go(); setp(1, 1, 1, 4'b1001, 4'hf); setp(2, 1, 1, 4'b1011, 4'hf);
    go(); go(); setg(1, 4'b0001); setg(2, 4'b1011);
    @(negedge clk);
    chk(rq(1) == 4'b1001, "R4", "winner requests", rq(1), 4'b1001);
    chk(rq(2) == '0, "R4", "loser silent", rq(2), 0);
    go(); setg(1, 4'b1001); setg(2, 0); push(1, 4'b1001, 1'b1, "R9");
    @(negedge clk);
    go(); setp(1, 0, 0, 0, 0); setg(1, 0);
    wc = 0; found = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (!found && rq(2) == 4'b1011) begin found = 1'b1; wc = k; end
      if (!found) go();
    end
    chk(found && wc <= GAP + 1, "R5", "retry after release cycles", wc, GAP + 1);
    go(); setg(2, 4'b1011); push(2, 4'b1011, 1'b1, "R9");
    @(negedge clk);
    go(); setp(2, 0, 0, 0, 0); setg(2, 0);

    // R4 round robin: pointer past 2, port 3 beats port 1
    go(); setp(1, 1, 1, 4'b0101, 4'hf); setp(3, 1, 1, 4'b0110, 4'hf);
    go(); go(); setg(3, 4'b0110); push(3, 4'b0110, 1'b1, "R4");
    @(negedge clk);
    chk(rq(1) == '0, "R4", "lower port waits", rq(1), 0);
    go(); setp(3, 0, 0, 0, 0); setg(3, 0);
    wc = 0; found = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (!found && rq(1) == 4'b0101) begin found = 1'b1; wc = k; end
      if (!found) go();
    end
    chk(found && wc <= GAP + 1, "R5", "second retry cycles", wc, GAP + 1);
    go(); setg(1, 4'b0101); push(1, 4'b0101, 1'b1, "R9");
    @(negedge clk);
    go(); setp(1, 0, 0, 0, 0); setg(1, 0);

    repeat (3) go();
    chk(expq.size() == 0, "R7", "all expected fires seen", expq.size(), 0);
    finish_run();
  end
endmodule